// File: doc/BRIEF.md
# Acquisition Sample Ring

This block is a circular store for 16-bit converter samples, sitting between a producer that delivers one sample per strobe and a host that drains them through a small register port. The ring holds 2003 slots, a depth that is not a power of two, so both pointers wrap by compare rather than by truncation. The producer side has no backpressure: each strobe either stores a sample at the write pointer or, when the ring is full, discards it and records an overrun.

The host reads stored samples by addressing the slot window directly, then hands the space back by writing its read pointer. The block derives the number of unread samples from the two pointers. It raises a sticky fill flag when that number climbs to a programmable level, and it collects overrun and converter-fault conditions as further sticky flags. A mask picks which flags drive the single interrupt line.

Top module: `acq_ring`

## Requirements
- R1: After a synchronous reset, the write pointer, read pointer, unread count, all flags and all mask bits are zero, the fill level register reads 1001 and `irq` is low.
- R2: A sample strobe while the ring is not full stores `smp_data` in the slot at the write pointer and advances the pointer by one, and the pointer goes from 2002 back to 0. The write pointer reads at address 0xFF0.
- R3: The unread count at address 0xFF2 equals write pointer minus read pointer, with 2003 added when that difference is negative.
- R4: The read pointer at address 0xFF1 is loaded by a host write. A written value of 2003 or more is ignored and leaves the pointer unchanged.
- R5: A host read at an address from 0x000 to 0x7D2 returns the sample stored in that slot. Every host read, whether of a slot or a register, shows its data on `bus_rdata` one cycle after the read strobe.
- R6: A sample strobe while 2002 samples are unread is dropped: the write pointer and all stored samples stay unchanged, and flag bit 1 (overrun) is set.
- R7: The fill level register at address 0xFF3 is writable. Flag bit 0 sets when the unread count moves from below the fill level to at or above it.
- R8: After an accepted read-pointer write, flag bit 0 sets again if the unread count is still at or above the fill level.
- R9: A one-cycle pulse on `conv_fault` sets flag bit 2.
- R10: The flags read at address 0xFF5. Writing to that address clears each flag whose data bit is 1 and leaves the others alone. A set event wins over a clear in the same cycle.
- R11: The mask at address 0xFF4 uses bits 2:0, one per flag. `irq` is high exactly when some flag is set and its mask bit is also set, so writing 0 to the mask silences it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | Producer sample strobe |
| smp_data | input | 16 | Producer sample value |
| conv_fault | input | 1 | Converter hardware fault pulse |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 12 | Host address (slot window or register) |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Host read data, registered |
| irq | output | 1 | Masked interrupt request |

## Verification
Read data, pointer moves, the unread count, the overrun and fault flags, and mask changes on `irq` all take effect at the clock edge that captures the strobe. The fill flag takes one edge more, because it compares the count that the pointers held after that edge. The bench drives and samples on falling edges. It follows every push burst and every register write with one idle cycle, so each later read captures state that has settled. It reads `bus_rdata` on the falling edge right after the edge that took the read strobe.

// File: rtl/acq_ring_pkg.sv
// Package: shared constants for the acquisition sample ring.
// Assumes a 12-bit host address space with registers above the slot window.
package acq_ring_pkg;
    localparam int HOST_AW = 12;
    localparam int NFLAG   = 3;

    // flag bit positions, decoded by host software
    localparam int FLG_THR = 0;
    localparam int FLG_OVR = 1;
    localparam int FLG_HWE = 2;

    typedef logic [NFLAG-1:0] flag_t;

    // register addresses, placed above any legal slot index
    localparam logic [HOST_AW-1:0] A_WPTR  = 12'hFF0;
    localparam logic [HOST_AW-1:0] A_RPTR  = 12'hFF1;
    localparam logic [HOST_AW-1:0] A_COUNT = 12'hFF2;
    localparam logic [HOST_AW-1:0] A_LEVEL = 12'hFF3;
    localparam logic [HOST_AW-1:0] A_MASK  = 12'hFF4;
    localparam logic [HOST_AW-1:0] A_FLAGS = 12'hFF5;
endpackage

// File: rtl/acq_ring_store.sv
// Module: acq_ring_store
// Sample memory with one write port and one registered read port.
// Assumes both indices are below DEPTH; the caller guarantees this.
module acq_ring_store #(
    parameter int DEPTH = 2003,
    parameter int DW    = 16,
    parameter int PW    = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_idx,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [PW-1:0] rd_idx,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] mem [DEPTH];

    // store an accepted sample
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_data;
    end

    // capture the addressed slot for the host
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= mem[rd_idx];
    end
endmodule

// File: rtl/acq_ring_ptrs.sv
// Module: acq_ring_ptrs
// Write/read pointers, modulo-DEPTH unread count and full detection.
// Assumes DEPTH fits in PW bits; one slot stays empty when full.
module acq_ring_ptrs #(
    parameter int DEPTH = 2003,
    parameter int PW    = 11,
    parameter int VW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          rear_ld,
    input  logic [VW-1:0] rear_val,
    output logic [PW-1:0] front,
    output logic [PW-1:0] rear,
    output logic [PW-1:0] count,
    output logic          accept,
    output logic          drop,
    output logic          rear_taken
);
    localparam logic [PW-1:0] LAST  = PW'(DEPTH - 1);
    localparam logic [PW-1:0] DEP_P = PW'(DEPTH);

    logic full;
    logic rear_ok;

    // unread count with explicit wrap correction
    always_comb begin
        if (front >= rear) count = front - rear;
        else               count = front + DEP_P - rear;
    end

    assign full    = (count == LAST);
    assign accept  = push & ~full;
    assign drop    = push & full;
    assign rear_ok = (rear_val < VW'(DEPTH));

    // advance the write pointer on each stored sample
    always_ff @(posedge clk) begin
        if (!rst_n)      front <= '0;
        else if (accept) front <= (front == LAST) ? '0 : front + 1'b1;
    end

    // load the host read pointer when in range
    always_ff @(posedge clk) begin
        if (!rst_n)                  rear <= '0;
        else if (rear_ld && rear_ok) rear <= rear_val[PW-1:0];
    end

    // one-cycle marker that a read-pointer load took effect
    always_ff @(posedge clk) begin
        if (!rst_n) rear_taken <= 1'b0;
        else        rear_taken <= rear_ld & rear_ok;
    end

    // R2
    front_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (front == (($past(front) == LAST) ? '0 : $past(front) + 1'b1)));

    // R6
    drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> $stable(front));

    // R4
    rear_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rear_ld && !rear_ok) |=> $stable(rear));

    // R3
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count < DEP_P);
endmodule

// File: rtl/acq_ring_irq.sv
// Module: acq_ring_irq
// Sticky event flags, fill-level detection, mask and interrupt output.
// Assumes event inputs are single-cycle and set has priority over clear.
module acq_ring_irq
    import acq_ring_pkg::*;
#(
    parameter int PW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] count,
    input  logic [PW-1:0] level,
    input  logic          drop,
    input  logic          hw_err,
    input  logic          rear_taken,
    input  logic          clr_en,
    input  flag_t         clr_bits,
    input  logic          mask_we,
    input  flag_t         mask_wd,
    output flag_t         flags,
    output flag_t         mask,
    output logic          irq
);
    logic  above;
    logic  above_q;
    logic  thr_hit;
    flag_t set_vec;

    assign above   = (count >= level);
    assign thr_hit = above & (~above_q | rear_taken);

    always_comb begin
        set_vec          = '0;
        set_vec[FLG_THR] = thr_hit;
        set_vec[FLG_OVR] = drop;
        set_vec[FLG_HWE] = hw_err;
    end

    // remember the previous comparison for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) above_q <= 1'b0;
        else        above_q <= above;
    end

    // one sticky flop per event source
    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)                      flags[g] <= 1'b0;
            else if (set_vec[g])             flags[g] <= 1'b1;
            else if (clr_en && clr_bits[g])  flags[g] <= 1'b0;
        end
    end

    // host-programmed interrupt enables
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (mask_we) mask <= mask_wd;
    end

    assign irq = |(flags & mask);

    // R7
    fill_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (above && !above_q) |=> flags[FLG_THR]);

    // R6
    ovr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> flags[FLG_OVR]);

    // R9
    hwe_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hw_err |=> flags[FLG_HWE]);
endmodule

// File: rtl/acq_ring.sv
// Module: acq_ring (top)
// Acquisition sample ring: producer port, host register/slot port, irq.
// Assumes DEPTH is below the register base 0xFF0 and fits in PW bits.
module acq_ring
    import acq_ring_pkg::*;
#(
    parameter int DEPTH    = 2003,
    parameter int DW       = 16,
    parameter int LVL_INIT = DEPTH / 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_valid,
    input  logic [DW-1:0]      smp_data,
    input  logic               conv_fault,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [HOST_AW-1:0] bus_addr,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    output logic               irq
);
    localparam int PW = $clog2(DEPTH);

    logic [PW-1:0] front, rear, count, level;
    logic          accept, drop, rear_taken;
    logic          in_win;
    logic [DW-1:0] slot_q, reg_q, reg_val;
    logic          win_q;
    flag_t         flags, mask;

    assign in_win = (bus_addr < HOST_AW'(DEPTH));

    acq_ring_ptrs #(.DEPTH(DEPTH), .PW(PW), .VW(DW)) u_ptrs (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (smp_valid),
        .rear_ld    (bus_wr && bus_addr == A_RPTR),
        .rear_val   (bus_wdata),
        .front      (front),
        .rear       (rear),
        .count      (count),
        .accept     (accept),
        .drop       (drop),
        .rear_taken (rear_taken)
    );

    acq_ring_store #(.DEPTH(DEPTH), .DW(DW), .PW(PW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (accept),
        .wr_idx  (front),
        .wr_data (smp_data),
        .rd_en   (bus_rd && in_win),
        .rd_idx  (bus_addr[PW-1:0]),
        .rd_data (slot_q)
    );

    acq_ring_irq #(.PW(PW)) u_irq (
        .clk        (clk),
        .rst_n      (rst_n),
        .count      (count),
        .level      (level),
        .drop       (drop),
        .hw_err     (conv_fault),
        .rear_taken (rear_taken),
        .clr_en     (bus_wr && bus_addr == A_FLAGS),
        .clr_bits   (bus_wdata[NFLAG-1:0]),
        .mask_we    (bus_wr && bus_addr == A_MASK),
        .mask_wd    (bus_wdata[NFLAG-1:0]),
        .flags      (flags),
        .mask       (mask),
        .irq        (irq)
    );

    // fill level register
    always_ff @(posedge clk) begin
        if (!rst_n)                           level <= PW'(LVL_INIT);
        else if (bus_wr && bus_addr == A_LEVEL) level <= bus_wdata[PW-1:0];
    end

    // register read selection
    always_comb begin
        case (bus_addr)
            A_WPTR:  reg_val = DW'(front);
            A_RPTR:  reg_val = DW'(rear);
            A_COUNT: reg_val = DW'(count);
            A_LEVEL: reg_val = DW'(level);
            A_MASK:  reg_val = DW'(mask);
            A_FLAGS: reg_val = DW'(flags);
            default: reg_val = '0;
        endcase
    end

    // capture register data and the window select on a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_q <= '0;
            win_q <= 1'b0;
        end else if (bus_rd) begin
            reg_q <= reg_val;
            win_q <= in_win;
        end
    end

    assign bus_rdata = win_q ? slot_q : reg_q;

    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_MASK && bus_wdata[NFLAG-1:0] == '0) |=> !irq);
endmodule

// File: tb/sim_acq_ring.sv
`timescale 1ns/1ps
module sim_acq_ring;
    localparam logic [11:0] T_WP = 12'hFF0, T_RP = 12'hFF1, T_CNT = 12'hFF2;
    localparam logic [11:0] T_LVL = 12'hFF3, T_MSK = 12'hFF4, T_FLG = 12'hFF5;
    localparam logic [1:0]  OP_WR = 2'd0, OP_RD = 2'd1, OP_PUSH = 2'd2, OP_IRQ = 2'd3;
    localparam int NV = 38;

    // {req, op, addr, data}
    localparam logic [33:0] VEC [NV] = '{
        {4'd1,  OP_RD,   T_WP,  16'd0},     // R1
        {4'd1,  OP_RD,   T_RP,  16'd0},     // R1
        {4'd1,  OP_RD,   T_CNT, 16'd0},     // R1
        {4'd1,  OP_RD,   T_FLG, 16'd0},     // R1
        {4'd1,  OP_RD,   T_MSK, 16'd0},     // R1
        {4'd1,  OP_RD,   T_LVL, 16'd1001},  // R1
        {4'd11, OP_IRQ,  12'h0, 16'd0},     // R11
        {4'd7,  OP_WR,   T_LVL, 16'd4},     // R7
        {4'd11, OP_WR,   T_MSK, 16'd1},     // R11
        {4'd2,  OP_PUSH, 12'h0, 16'd3},     // R2
        {4'd2,  OP_RD,   T_WP,  16'd3},     // R2
        {4'd3,  OP_RD,   T_CNT, 16'd3},     // R3
        {4'd7,  OP_RD,   T_FLG, 16'd0},     // R7
        {4'd11, OP_IRQ,  12'h0, 16'd0},     // R11
        {4'd7,  OP_PUSH, 12'h0, 16'd1},     // R7
        {4'd7,  OP_RD,   T_FLG, 16'd1},     // R7
        {4'd11, OP_IRQ,  12'h0, 16'd1},     // R11
        {4'd5,  OP_RD,   12'h0, 16'hA000},  // R5
        {4'd5,  OP_RD,   12'h3, 16'hA003},  // R5
        {4'd10, OP_WR,   T_FLG, 16'd1},     // R10
        {4'd10, OP_RD,   T_FLG, 16'd0},     // R10
        {4'd11, OP_IRQ,  12'h0, 16'd0},     // R11
        {4'd4,  OP_WR,   T_RP,  16'd1},     // R4
        {4'd4,  OP_RD,   T_RP,  16'd1},     // R4
        {4'd3,  OP_RD,   T_CNT, 16'd3},     // R3
        {4'd8,  OP_RD,   T_FLG, 16'd0},     // R8
        {4'd7,  OP_PUSH, 12'h0, 16'd2},     // R7
        {4'd7,  OP_RD,   T_FLG, 16'd1},     // R7
        {4'd10, OP_WR,   T_FLG, 16'd1},     // R10
        {4'd10, OP_RD,   T_FLG, 16'd0},     // R10
        {4'd8,  OP_WR,   T_RP,  16'd2},     // R8
        {4'd8,  OP_RD,   T_FLG, 16'd1},     // R8
        {4'd4,  OP_WR,   T_RP,  16'd2003},  // R4
        {4'd4,  OP_RD,   T_RP,  16'd2},     // R4
        {4'd3,  OP_RD,   T_CNT, 16'd4},     // R3
        {4'd11, OP_WR,   T_MSK, 16'd0},     // R11
        {4'd11, OP_IRQ,  12'h0, 16'd0},     // R11
        {4'd5,  OP_RD,   12'h5, 16'hA005}   // R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_data = '0;
    logic        conv_fault = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        irq;

    int n_run = 0, n_fail = 0, seq = 0;

    always #2.5 clk = ~clk;

    acq_ring u0 (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .conv_fault(conv_fault), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] v);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
    endtask

    task automatic push(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); smp_valid = 1'b1; smp_data = 16'hA000 + 16'(seq);
            seq++;
        end
        @(negedge clk); smp_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=expired expected=completion");
        summary();
    end

    initial begin
        logic [15:0] v;
        string tag;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < NV; k++) begin
            tag = $sformatf("R%0d vec%0d", VEC[k][33:30], k);
            case (VEC[k][29:28])
                OP_WR:   wr(VEC[k][27:16], VEC[k][15:0]);
                OP_RD:   begin rd(VEC[k][27:16], v); check(tag, v, VEC[k][15:0]); end
                OP_PUSH: push(int'(VEC[k][15:0]));
                default: begin @(negedge clk); check(tag, 16'(irq), VEC[k][15:0]); end
            endcase
        end

        // R9: converter fault pulse, fill flag still set from the table
        @(negedge clk); conv_fault = 1'b1;
        @(negedge clk); conv_fault = 1'b0;
        rd(T_FLG, v); check("R9 fault flag", v, 16'd5);
        // R10: clear all
        wr(T_FLG, 16'd7);
        rd(T_FLG, v); check("R10 clear all", v, 16'd0);
        // R3: drain everything, count zero
        wr(T_LVL, 16'd2047);
        wr(T_RP, 16'd6);
        rd(T_CNT, v); check("R3 empty count", v, 16'd0);
        // R6: overfill by three
        wr(T_MSK, 16'd2);
        push(2005);
        rd(T_CNT, v); check("R6 full count", v, 16'd2002);
        rd(T_WP, v);  check("R2 wrapped front", v, 16'd5);
        rd(T_FLG, v); check("R6 overrun flag", v, 16'd2);
        @(negedge clk); check("R11 irq on overrun", 16'(irq), 16'd1);
        rd(12'd5, v); check("R6 empty slot untouched", v, 16'hA005);
        rd(12'd4, v); check("R6 last accepted", v, 16'hA000 + 16'd2007);
        rd(12'd2002, v); check("R5 top slot", v, 16'hA000 + 16'd2002);
        // R3: front below rear
        wr(T_RP, 16'd16);
        rd(T_CNT, v); check("R3 wrapped count", v, 16'd1992);
        // R1: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd(T_WP, v);  check("R1 front after reset", v, 16'd0);
        rd(T_FLG, v); check("R1 flags after reset", v, 16'd0);
        rd(T_LVL, v); check("R1 level after reset", v, 16'd1001);
        @(negedge clk); check("R1 irq after reset", 16'(irq), 16'd0);
        summary();
    end
endmodule